// File: doc/BRIEF.md
# Triple Digital Potentiometer Wiper Controller

This block drives the wipers of three digitally controlled potentiometers with 100, 256 and 64 taps. Each pot has a volatile wiper register that selects the active tap. It also has a shadow register, which stands for nonvolatile storage and is built here as ordinary flops. A supply-valid input qualifies power-up. After power-up, the block copies every shadow value into its wiper register once the supply has stayed valid for a programmable number of cycles. Until then, the wipers sit at fixed start taps.

A parallel command port stands in for a serial slave. It carries a 2-bit pot select code, a data byte and three strobes: volatile write, nonvolatile write and read. Each pot drives a one-hot tap enable vector. When a wiper moves, the new tap turns on one cycle before the old tap turns off.

Top module: `dcp_wiper_ctrl`

## Requirements
- R1: After reset, pot A (100 taps) sits at tap 0, pot B (256 taps) at tap 255 and pot C (64 taps) at tap 63, with `recall_done`, `busy` and `rd_valid` low.
- R2: `settle_sel` codes 0, 1, 2 and 3 pick SETTLE_0..SETTLE_3 cycles. The recall happens on the Nth consecutive rising clock edge that samples `pwr_ok` high. On that edge every wiper takes its shadow value and `recall_done` rises. The shadow registers reset to 50, 128 and 32 for pots A, B and C.
- R3: If `pwr_ok` goes low before the recall, the count restarts from zero. If `pwr_ok` goes low after the recall, `recall_done` clears and every wiper returns to its R1 start tap on the next edge.
- R4: A nonvolatile write (`cmd_nvwr`) sets the selected wiper and its shadow on the same edge. A later power cycle recalls that value.
- R5: A volatile write (`cmd_vwr`) sets only the selected wiper. After a power cycle, the wiper holds the shadow value again.
- R6: A read (`cmd_rd`) returns the selected wiper register, not the shadow. The value appears on `rd_data` with `rd_valid` high one cycle after the strobe. Select code 3 reads as 0.
- R7: `cmd_sel` 0 targets pot A, 1 targets pot B and 2 targets pot C. Code 3 targets no pot, and a write with code 3 changes nothing.
- R8: In steady state each tap enable vector has exactly one bit set, at the index equal to the wiper value.
- R9: After a wiper moves, the old and new tap bits are both high for exactly one cycle, then only the new bit remains.
- R10: A written value above a pot's highest tap (99, 255 or 63) is clamped to that tap.
- R11: A command strobed while `recall_done` is low changes nothing and produces no read. `busy` is high for the cycle after such a strobe.
- R12: If several strobes come together, a nonvolatile write beats a volatile write, which beats a read. Only the winner is carried out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_ok | input | 1 | Supply-valid indication |
| settle_sel | input | 2 | Settle time select code |
| cmd_sel | input | 2 | Pot select code |
| cmd_data | input | 8 | Write data |
| cmd_vwr | input | 1 | Volatile write strobe |
| cmd_nvwr | input | 1 | Nonvolatile write strobe |
| cmd_rd | input | 1 | Read strobe |
| rd_data | output | 8 | Read result |
| rd_valid | output | 1 | Read result valid |
| busy | output | 1 | Command was rejected before recall |
| recall_done | output | 1 | Power-up recall completed |
| tap_en_a | output | TAPS_A | One-hot tap enables, pot A |
| tap_en_b | output | TAPS_B | One-hot tap enables, pot B |
| tap_en_c | output | TAPS_C | One-hot tap enables, pot C |

## Verification
The bench keeps the default tap counts (100, 256 and 64) and shadow reset values, so the clamp boundaries, the start taps and the recalled taps are the real ones. It builds the block with settle counts of 4, 8, 12 and 20 instead of the larger defaults. With these counts, all four settle codes can be timed edge by edge, including the cycle just before the recall. The short window also makes it cheap to drop supply-valid one cycle before the recall and to power-cycle many times, which proves that volatile writes are lost and nonvolatile writes survive.

// File: rtl/dcp_pkg.sv
// Package: shared types and the strobe priority function for the
// potentiometer wiper controller.
package dcp_pkg;

    localparam int WIPER_W  = 8;
    localparam int NUM_POTS = 3;

    typedef logic [WIPER_W-1:0] wiper_t;

    typedef enum logic [1:0] {
        OP_NONE    = 2'd0,
        OP_READ    = 2'd1,
        OP_VWRITE  = 2'd2,
        OP_NVWRITE = 2'd3
    } op_e;

    // Collapse the three strobes into one operation: nonvolatile first,
    // then volatile, then read.
    function automatic op_e pick_op(input logic nv, input logic v, input logic rd);
        if (nv)      return OP_NVWRITE;
        else if (v)  return OP_VWRITE;
        else if (rd) return OP_READ;
        else         return OP_NONE;
    endfunction

endpackage

// File: rtl/dcp_settle_timer.sv
// Module: counts consecutive cycles of supply-valid and issues a one-cycle
// recall pulse when the selected settle count is reached.
// Assumes: every SETTLE_x is at least 1; settle_sel may change at any time
// and the current code is used for the comparison.
module dcp_settle_timer #(
    parameter int SETTLE_0 = 16,
    parameter int SETTLE_1 = 64,
    parameter int SETTLE_2 = 256,
    parameter int SETTLE_3 = 1024
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_ok,
    input  logic [1:0] settle_sel,
    output logic       recall,
    output logic       done
);
    localparam int MAX01 = (SETTLE_0 > SETTLE_1) ? SETTLE_0 : SETTLE_1;
    localparam int MAX23 = (SETTLE_2 > SETTLE_3) ? SETTLE_2 : SETTLE_3;
    localparam int SMAX  = (MAX01 > MAX23) ? MAX01 : MAX23;
    localparam int CW    = $clog2(SMAX + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;

    // Select the terminal count (settle cycles minus one).
    always_comb begin
        case (settle_sel)
            2'd0:    limit = CW'(SETTLE_0 - 1);
            2'd1:    limit = CW'(SETTLE_1 - 1);
            2'd2:    limit = CW'(SETTLE_2 - 1);
            default: limit = CW'(SETTLE_3 - 1);
        endcase
    end

    assign recall = pwr_ok && !done && (cnt >= limit);

    // Count qualified cycles and hold the done flag until supply drops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (!pwr_ok) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (recall) begin
            done <= 1'b1;
        end else if (!done) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/dcp_cmd_decode.sv
// Module: turns the parallel command strobes into per-pot write enables,
// a read enable and a rejection pulse.
// Assumes: select code 3 addresses no pot; commands are only accepted
// once the recall is done.
module dcp_cmd_decode
    import dcp_pkg::*;
#(
    parameter int NPOTS = NUM_POTS
) (
    input  logic             recall_done,
    input  logic [1:0]       cmd_sel,
    input  logic             cmd_vwr,
    input  logic             cmd_nvwr,
    input  logic             cmd_rd,
    output logic [NPOTS-1:0] wr_en,
    output logic             wr_nv,
    output logic             rd_en,
    output logic             reject
);
    op_e op;

    // Resolve strobe priority.
    assign op = pick_op(cmd_nvwr, cmd_vwr, cmd_rd);

    // Address decode for writes, one enable per pot.
    for (genvar g = 0; g < NPOTS; g++) begin : g_wsel
        assign wr_en[g] = recall_done && (cmd_sel == 2'(g)) &&
                          ((op == OP_VWRITE) || (op == OP_NVWRITE));
    end

    assign wr_nv  = (op == OP_NVWRITE);
    assign rd_en  = recall_done && (op == OP_READ);
    assign reject = !recall_done && (op != OP_NONE);

endmodule

// File: rtl/dcp_wiper_channel.sv
// Module: one potentiometer. Holds the volatile wiper and the shadow value,
// clamps written data, and decodes the wiper with make-before-break by
// also enabling the previous cycle's tap.
// Assumes: NTAPS is between 2 and 256; INIT_TAP and SHADOW_RST < NTAPS.
module dcp_wiper_channel
    import dcp_pkg::*;
#(
    parameter int NTAPS      = 100,
    parameter int INIT_TAP   = 0,
    parameter int SHADOW_RST = 50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_ok,
    input  logic             recall,
    input  logic             wr_en,
    input  logic             wr_nv,
    input  wiper_t           wr_data,
    output wiper_t           wiper,
    output logic [NTAPS-1:0] tap_en
);
    localparam wiper_t TOP_TAP = wiper_t'(NTAPS - 1);
    localparam wiper_t INIT_V  = wiper_t'(INIT_TAP);
    localparam wiper_t SHRST_V = wiper_t'(SHADOW_RST);

    wiper_t shadow;
    wiper_t prev;
    wiper_t wr_clamped;

    // Limit write data to the highest tap of this pot.
    assign wr_clamped = (int'(wr_data) > NTAPS - 1) ? TOP_TAP : wr_data;

    // Shadow storage: changes only on a nonvolatile write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shadow <= SHRST_V;
        else if (wr_en && wr_nv)
            shadow <= wr_clamped;
    end

    // Wiper register: start tap while unpowered, recall, then writes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wiper <= INIT_V;
        else if (!pwr_ok)
            wiper <= INIT_V;
        else if (recall)
            wiper <= shadow;
        else if (wr_en)
            wiper <= wr_clamped;
    end

    // Previous wiper value, keeps the old tap on for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev <= INIT_V;
        else
            prev <= wiper;
    end

    // Tap decode: current tap plus the tap held over from the last cycle.
    for (genvar i = 0; i < NTAPS; i++) begin : g_tap
        assign tap_en[i] = (wiper == wiper_t'(i)) || (prev == wiper_t'(i));
    end

endmodule

// File: rtl/dcp_wiper_ctrl.sv
// Module: top of the triple potentiometer wiper controller. Connects the
// settle timer, the command decoder and three wiper channels, and registers
// read data and the rejection flag.
// Assumes: pot A/B/C start taps are 0, TAPS_B-1 and TAPS_C-1.
module dcp_wiper_ctrl
    import dcp_pkg::*;
#(
    parameter int TAPS_A     = 100,
    parameter int TAPS_B     = 256,
    parameter int TAPS_C     = 64,
    parameter int SHADOW_A   = 50,
    parameter int SHADOW_B   = 128,
    parameter int SHADOW_C   = 32,
    parameter int SETTLE_0   = 16,
    parameter int SETTLE_1   = 64,
    parameter int SETTLE_2   = 256,
    parameter int SETTLE_3   = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_ok,
    input  logic [1:0]        settle_sel,
    input  logic [1:0]        cmd_sel,
    input  logic [7:0]        cmd_data,
    input  logic              cmd_vwr,
    input  logic              cmd_nvwr,
    input  logic              cmd_rd,
    output logic [7:0]        rd_data,
    output logic              rd_valid,
    output logic              busy,
    output logic              recall_done,
    output logic [TAPS_A-1:0] tap_en_a,
    output logic [TAPS_B-1:0] tap_en_b,
    output logic [TAPS_C-1:0] tap_en_c
);
    localparam int INIT_A = 0;
    localparam int INIT_B = TAPS_B - 1;
    localparam int INIT_C = TAPS_C - 1;

    logic                recall;
    logic [NUM_POTS-1:0] wr_en;
    logic                wr_nv;
    logic                rd_en;
    logic                reject;
    wiper_t              wiper_all [NUM_POTS];

    dcp_settle_timer #(
        .SETTLE_0 (SETTLE_0),
        .SETTLE_1 (SETTLE_1),
        .SETTLE_2 (SETTLE_2),
        .SETTLE_3 (SETTLE_3)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_ok     (pwr_ok),
        .settle_sel (settle_sel),
        .recall     (recall),
        .done       (recall_done)
    );

    dcp_cmd_decode #(
        .NPOTS (NUM_POTS)
    ) u_dec (
        .recall_done (recall_done),
        .cmd_sel     (cmd_sel),
        .cmd_vwr     (cmd_vwr),
        .cmd_nvwr    (cmd_nvwr),
        .cmd_rd      (cmd_rd),
        .wr_en       (wr_en),
        .wr_nv       (wr_nv),
        .rd_en       (rd_en),
        .reject      (reject)
    );

    for (genvar g = 0; g < NUM_POTS; g++) begin : g_pot
        localparam int NT = (g == 0) ? TAPS_A   : (g == 1) ? TAPS_B   : TAPS_C;
        localparam int IT = (g == 0) ? INIT_A   : (g == 1) ? INIT_B   : INIT_C;
        localparam int SR = (g == 0) ? SHADOW_A : (g == 1) ? SHADOW_B : SHADOW_C;

        logic [NT-1:0] en;

        dcp_wiper_channel #(
            .NTAPS      (NT),
            .INIT_TAP   (IT),
            .SHADOW_RST (SR)
        ) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .pwr_ok  (pwr_ok),
            .recall  (recall),
            .wr_en   (wr_en[g]),
            .wr_nv   (wr_nv),
            .wr_data (cmd_data),
            .wiper   (wiper_all[g]),
            .tap_en  (en)
        );

        if (g == 0) begin : g_out_a
            assign tap_en_a = en;
        end else if (g == 1) begin : g_out_b
            assign tap_en_b = en;
        end else begin : g_out_c
            assign tap_en_c = en;
        end
    end

    // Register read results and the rejection pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
            busy     <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            busy     <= reject;
            if (rd_en) begin
                case (cmd_sel)
                    2'd0:    rd_data <= wiper_all[0];
                    2'd1:    rd_data <= wiper_all[1];
                    2'd2:    rd_data <= wiper_all[2];
                    default: rd_data <= '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/dcp_wiper_ctrl_chk.sv
// Module: property checker for the wiper controller, attached by bind.
module dcp_wiper_ctrl_chk #(
    parameter int TAPS_A = 100,
    parameter int TAPS_B = 256,
    parameter int TAPS_C = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pwr_ok,
    input logic              cmd_rd,
    input logic              rd_valid,
    input logic              busy,
    input logic              recall_done,
    input logic [TAPS_A-1:0] tap_en_a,
    input logic [TAPS_B-1:0] tap_en_b,
    input logic [TAPS_C-1:0] tap_en_c
);
    // R8
    tap_a_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(tap_en_a) >= 1) && ($countones(tap_en_a) <= 2));
    // R8
    tap_b_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(tap_en_b) >= 1) && ($countones(tap_en_b) <= 2));
    // R8
    tap_c_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(tap_en_c) >= 1) && ($countones(tap_en_c) <= 2));
    // R11
    busy_only_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !$past(recall_done));
    // R3
    drop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |=> !recall_done);
    // R2
    recall_powered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(recall_done) |-> $past(pwr_ok));
    // R6
    read_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(cmd_rd && recall_done));
endmodule

bind dcp_wiper_ctrl dcp_wiper_ctrl_chk #(
    .TAPS_A (TAPS_A),
    .TAPS_B (TAPS_B),
    .TAPS_C (TAPS_C)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_ok      (pwr_ok),
    .cmd_rd      (cmd_rd),
    .rd_valid    (rd_valid),
    .busy        (busy),
    .recall_done (recall_done),
    .tap_en_a    (tap_en_a),
    .tap_en_b    (tap_en_b),
    .tap_en_c    (tap_en_c)
);

// File: tb/dcp_wiper_ctrl_test.sv
// Directed bench for the triple potentiometer wiper controller.
module dcp_wiper_ctrl_test;
    localparam int S0 = 4, S1 = 8, S2 = 12, S3 = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_ok = 1'b0;
    logic [1:0] settle_sel = 2'd0;
    logic [1:0] cmd_sel = 2'd0;
    logic [7:0] cmd_data = 8'd0;
    logic       cmd_vwr = 1'b0, cmd_nvwr = 1'b0, cmd_rd = 1'b0;
    logic [7:0] rd_data;
    logic       rd_valid, busy, recall_done;
    logic [99:0]  tap_en_a;
    logic [255:0] tap_en_b;
    logic [63:0]  tap_en_c;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    dcp_wiper_ctrl #(
        .SETTLE_0 (S0), .SETTLE_1 (S1), .SETTLE_2 (S2), .SETTLE_3 (S3)
    ) uut (
        .clk (clk), .rst_n (rst_n), .pwr_ok (pwr_ok), .settle_sel (settle_sel),
        .cmd_sel (cmd_sel), .cmd_data (cmd_data), .cmd_vwr (cmd_vwr),
        .cmd_nvwr (cmd_nvwr), .cmd_rd (cmd_rd), .rd_data (rd_data),
        .rd_valid (rd_valid), .busy (busy), .recall_done (recall_done),
        .tap_en_a (tap_en_a), .tap_en_b (tap_en_b), .tap_en_c (tap_en_c)
    );

    // Index of the single set bit, -1 if not exactly one.
    function automatic int tap_pos(input logic [255:0] v);
        int c = 0;
        int p = -1;
        for (int i = 0; i < 256; i++) if (v[i]) begin c++; p = i; end
        return (c == 1) ? p : -1;
    endfunction

    function automatic int pos_a(); return tap_pos({156'd0, tap_en_a}); endfunction
    function automatic int pos_b(); return tap_pos(tap_en_b); endfunction
    function automatic int pos_c(); return tap_pos({192'd0, tap_en_c}); endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Strobe one command for one edge; returns at the following negedge.
    task automatic cmd(input bit nv, input bit v, input bit rd,
                       input logic [1:0] sel, input logic [7:0] d);
        cmd_nvwr = nv; cmd_vwr = v; cmd_rd = rd; cmd_sel = sel; cmd_data = d;
        cyc(1);
        cmd_nvwr = 0; cmd_vwr = 0; cmd_rd = 0;
    endtask

    task automatic power_up(input logic [1:0] code, input int n);
        settle_sel = code;
        pwr_ok = 1'b1;
        cyc(n - 1);
        check("R2 not done one edge early", int'(recall_done), 0);
        cyc(1);
        check("R2 done on Nth edge", int'(recall_done), 1);
        cyc(1);
    endtask

    task automatic power_down();
        pwr_ok = 1'b0;
        cyc(2);
        check("R3 done cleared", int'(recall_done), 0);
        check("R3 pot A start tap", pos_a(), 0);
        check("R3 pot B start tap", pos_b(), 255);
        check("R3 pot C start tap", pos_c(), 63);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        check("R1 pot A", pos_a(), 0);
        check("R1 pot B", pos_b(), 255);
        check("R1 pot C", pos_c(), 63);
        check("R1 done", int'(recall_done), 0);
        check("R1 busy", int'(busy), 0);
        check("R1 rd_valid", int'(rd_valid), 0);
    endtask

    task automatic t_busy_before_recall();
        cmd(1, 0, 0, 2'd0, 8'd5);
        check("R11 busy pulse", int'(busy), 1);
        check("R11 wiper untouched", pos_a(), 0);
        cmd(0, 0, 1, 2'd0, 8'd0);
        check("R11 no read", int'(rd_valid), 0);
        cyc(1);
        check("R11 busy drops", int'(busy), 0);
    endtask

    task automatic t_first_recall();
        settle_sel = 2'd0;
        pwr_ok = 1'b1;
        cyc(S0);
        check("R2 done code0", int'(recall_done), 1);
        check("R9 old tap A still on", int'(tap_en_a[0]), 1);
        check("R9 new tap A on", int'(tap_en_a[50]), 1);
        cyc(1);
        check("R2 recall A (R11 shadow kept)", pos_a(), 50);
        check("R2 recall B", pos_b(), 128);
        check("R2 recall C", pos_c(), 32);
    endtask

    task automatic t_settle_codes();
        power_down(); power_up(2'd1, S1);
        power_down(); power_up(2'd2, S2);
        power_down(); power_up(2'd3, S3);
        check("R8 pot B after code3", pos_b(), 128);
    endtask

    task automatic t_glitch();
        power_down();
        settle_sel = 2'd1;
        pwr_ok = 1'b1;
        cyc(S1 - 1);
        pwr_ok = 1'b0;
        cyc(1);
        pwr_ok = 1'b1;
        cyc(S1 - 1);
        check("R3 restart not done", int'(recall_done), 0);
        cyc(1);
        check("R3 restart done", int'(recall_done), 1);
        cyc(1);
    endtask

    task automatic t_volatile();
        cmd(0, 1, 0, 2'd0, 8'd20);
        check("R9 both taps new", int'(tap_en_a[20]), 1);
        check("R9 both taps old", int'(tap_en_a[50]), 1);
        cyc(1);
        check("R9 single after", pos_a(), 20);
        check("R7 pot B untouched", pos_b(), 128);
        cmd(0, 0, 1, 2'd0, 8'd0);
        check("R6 rd_valid", int'(rd_valid), 1);
        check("R6 read wiper A", int'(rd_data), 20);
        power_down(); power_up(2'd0, S0);
        check("R5 back to shadow", pos_a(), 50);
    endtask

    task automatic t_nonvolatile();
        cmd(1, 0, 0, 2'd1, 8'd77);
        cyc(1);
        check("R4 wiper B", pos_b(), 77);
        check("R7 pot A untouched", pos_a(), 50);
        check("R7 pot C untouched", pos_c(), 32);
        cmd(0, 1, 0, 2'd1, 8'd40);
        cmd(0, 0, 1, 2'd1, 8'd0);
        check("R6 read gives wiper not shadow", int'(rd_data), 40);
        power_down(); power_up(2'd0, S0);
        check("R4 survives power cycle", pos_b(), 77);
    endtask

    task automatic t_clamp();
        cmd(0, 1, 0, 2'd0, 8'd200);
        cyc(1);
        check("R10 pot A clamp", pos_a(), 99);
        cmd(1, 0, 0, 2'd2, 8'd250);
        cyc(1);
        check("R10 pot C clamp", pos_c(), 63);
        cmd(0, 1, 0, 2'd1, 8'd255);
        cyc(1);
        check("R10 pot B top", pos_b(), 255);
        cmd(0, 1, 0, 2'd2, 8'd64);
        cyc(1);
        check("R10 pot C 64 clamps", pos_c(), 63);
    endtask

    task automatic t_sel3();
        cmd(0, 1, 0, 2'd3, 8'd10);
        cyc(1);
        check("R7 code3 A", pos_a(), 99);
        check("R7 code3 B", pos_b(), 255);
        check("R7 code3 C", pos_c(), 63);
        cmd(0, 0, 1, 2'd3, 8'd0);
        check("R6 code3 rd_valid", int'(rd_valid), 1);
        check("R6 code3 data", int'(rd_data), 0);
    endtask

    task automatic t_priority();
        cmd(1, 1, 1, 2'd2, 8'd10);
        check("R12 read suppressed", int'(rd_valid), 0);
        cyc(1);
        check("R12 write applied", pos_c(), 10);
        cmd(0, 1, 1, 2'd0, 8'd33);
        check("R12 vwrite over read", int'(rd_valid), 0);
        cyc(1);
        check("R12 vwrite applied", pos_a(), 33);
        power_down(); power_up(2'd0, S0);
        check("R12 nv stored", pos_c(), 10);
        check("R5 A reverts", pos_a(), 50);
    endtask

    initial begin
        t_reset();
        t_busy_before_recall();
        t_first_recall();
        t_settle_codes();
        t_glitch();
        t_volatile();
        t_nonvolatile();
        t_clamp();
        t_sel3();
        t_priority();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule